// File: doc/BRIEF.md
# Processor Event Wait Unit

This unit holds a small processor core in a blocking stall until one selected event occurs, then lets the core continue in the very next cycle without saving or restoring any state. The core issues a single request that names the event kind and supplies either a counter target or a pin pattern and mask. From then on the unit compares every clock cycle until the event happens. There are three event kinds. A time wait ends when a shared free-running system counter equals a target value. A pin-equal wait ends when the masked input pins match a pattern. A pin-differ wait ends when the masked input pins no longer match a pattern, which lets software detect any change on a watched group of pins.

While a wait is armed the unit drives the core's clock-enable low, so the core's internal state does not advance. Only one kind can be armed at a time. A pin condition cannot be combined with a timeout. Completion is signalled by a one-cycle done pulse. It carries no information about which pins caused the match, so the core must read the pins again afterwards. The pins pass through a synchronizer before they are compared. The counter is taken to be in the unit's own clock domain.

Top module: `evt_wait_unit`

## Requirements
- R1: Once reset is released and before any request, busy and done are 0 and core_ce is 1.
- R2: When the unit is idle and req_valid is high with a legal req_kind, the request is accepted at that clock edge. From the next cycle, busy is 1 and core_ce is 0. core_ce is always the inverse of busy.
- R3: A time wait (req_kind 0) completes at the first clock edge at which busy is 1 and sys_cnt equals the captured target.
- R4: A pin-equal wait (req_kind 1) completes at the first clock edge at which busy is 1 and (synchronized pins AND mask) equals the captured pattern, compared over all bits.
- R5: A pin-differ wait (req_kind 2) completes at the first clock edge at which busy is 1 and (synchronized pins AND mask) differs from the captured pattern.
- R6: pins_in passes through two register stages before it is compared. A pin change driven before edge k can complete a wait at edge k+2 at the earliest.
- R7: On completion, done is 1 for exactly one cycle. In that same cycle busy is 0 and core_ce is 1.
- R8: A request presented while busy is 1 is ignored. The armed kind, target, pattern and mask stay as they were.
- R9: If a request's condition is already true when it is accepted, it completes at the next clock edge, so busy is high for exactly one cycle.
- R10: Time matching is exact equality on a wrapping 32-bit counter. A target the counter has already passed is matched only after the counter wraps around to it.
- R11: A request with req_kind 3 is never accepted. busy stays 0 and no done pulse follows.
- R12: Pins whose mask bit is 0 have no effect on a pin wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Wait request strobe |
| req_kind | input | 2 | 0 time, 1 pins equal, 2 pins differ, 3 reserved |
| req_target | input | CNT_W | Counter value for a time wait |
| req_pattern | input | PIN_W | Pattern for a pin wait |
| req_mask | input | PIN_W | Pins that take part in a pin wait |
| pins_in | input | PIN_W | Asynchronous input pins |
| sys_cnt | input | CNT_W | Shared free-running system counter |
| busy | output | 1 | Wait armed, core stalled |
| done | output | 1 | One-cycle completion pulse |
| core_ce | output | 1 | Core clock-enable, low during a stall |

## Verification
The bench targets the following corner cases, each chosen to expose a specific error:
- A time target the counter has already passed. A design using a greater-or-equal comparison would release the core at once instead of after the wrap.
- Requests issued while a wait is armed. A design that re-captures them would complete on the wrong event.
- Toggling pins outside the mask. A design that ignores the mask would wake the core falsely.
- A condition that is already true at request time, and the exact two-stage synchronizer delay. A design with an extra or a missing pipeline stage would produce a done pulse that is off by one cycle.
- The reserved kind. A design that accepts it could leave the core stalled for good.

// File: rtl/evw_pkg.sv
package evw_pkg;
   typedef enum logic [1:0] {
      EVW_TIME   = 2'd0,
      EVW_PIN_EQ = 2'd1,
      EVW_PIN_NE = 2'd2,
      EVW_RSVD   = 2'd3
   } evw_kind_e;
endpackage

// File: rtl/evw_sync.sv
module evw_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("evw_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/evw_cond.sv
module evw_cond
   import evw_pkg::*;
#(
   parameter int PIN_W = 32,
   parameter int CNT_W = 32
) (
   input  evw_kind_e        kind,
   input  logic [CNT_W-1:0] target,
   input  logic [PIN_W-1:0] pattern,
   input  logic [PIN_W-1:0] mask,
   input  logic [PIN_W-1:0] pins,
   input  logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [PIN_W-1:0] watched;
   logic             pins_same;

   assign watched   = pins & mask;
   assign pins_same = (watched == pattern);

   always_comb begin
      unique case (kind)
         EVW_TIME:   hit = (cnt == target);
         EVW_PIN_EQ: hit = pins_same;
         EVW_PIN_NE: hit = !pins_same;
         default:    hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/evt_wait_unit.sv
module evt_wait_unit
   import evw_pkg::*;
#(
   parameter int PIN_W       = 32,
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [CNT_W-1:0] req_target,
   input  logic [PIN_W-1:0] req_pattern,
   input  logic [PIN_W-1:0] req_mask,
   input  logic [PIN_W-1:0] pins_in,
   input  logic [CNT_W-1:0] sys_cnt,
   output logic             busy,
   output logic             done,
   output logic             core_ce
);
   generate
      if (PIN_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("evt_wait_unit: widths must be at least 1");
      end
   endgenerate

   logic [PIN_W-1:0] pins_s;
   logic             busy_q, done_q, hit, accept, fire;
   evw_kind_e        kind_q;
   logic [CNT_W-1:0] target_q;
   logic [PIN_W-1:0] pattern_q, mask_q;

   evw_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_in),
      .q     (pins_s)
   );

   evw_cond #(.PIN_W(PIN_W), .CNT_W(CNT_W)) i_cond (
      .kind    (kind_q),
      .target  (target_q),
      .pattern (pattern_q),
      .mask    (mask_q),
      .pins    (pins_s),
      .cnt     (sys_cnt),
      .hit     (hit)
   );

   assign accept = !busy_q && req_valid && (evw_kind_e'(req_kind) != EVW_RSVD);
   assign fire   = busy_q && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         kind_q    <= EVW_TIME;
         target_q  <= '0;
         pattern_q <= '0;
         mask_q    <= '0;
      end else begin
         done_q <= fire;
         if (accept) begin
            busy_q    <= 1'b1;
            kind_q    <= evw_kind_e'(req_kind);
            target_q  <= req_target;
            pattern_q <= req_pattern;
            mask_q    <= req_mask;
         end else if (fire) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign core_ce = !busy_q;

   AST_ACCEPT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && req_kind != 2'd3) |=> busy);  // R2
   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && req_kind == 2'd3) |=> !busy);  // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R7
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && core_ce));  // R7
   AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));  // R7
   AST_TIME_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind_q == EVW_TIME) |-> ($past(sys_cnt) == target_q));  // R3
   AST_ARGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(target_q) && $stable(pattern_q)
                                     && $stable(mask_q) && $stable(kind_q)));  // R8
endmodule

// File: tb/test_evt_wait_unit.sv
`timescale 1ns/1ps
module test_evt_wait_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [31:0] req_target = '0, req_pattern = '0, req_mask = '0;
   logic [31:0] pins_in = '0, sys_cnt = '0;
   logic        busy, done, core_ce;

   int    n_checks = 0, n_errors = 0;
   bit    finished = 0;
   string cur_tag = "R1";

   // model state
   bit          m_busy = 0, m_done = 0;
   logic [1:0]  m_kind = 0;
   logic [31:0] m_tgt = 0, m_pat = 0, m_msk = 0, m_s1 = 0, m_s2 = 0;

   always #4 clk = ~clk;

   evt_wait_unit i_evt_wait_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_target(req_target), .req_pattern(req_pattern), .req_mask(req_mask),
      .pins_in(pins_in), .sys_cnt(sys_cnt), .busy(busy), .done(done), .core_ce(core_ce)
   );

   function automatic bit cond_f(logic [1:0] k, logic [31:0] t, logic [31:0] p,
                                 logic [31:0] m, logic [31:0] pn, logic [31:0] c);
      case (k)
         2'd0: return c == t;
         2'd1: return (pn & m) == p;
         2'd2: return (pn & m) != p;
         default: return 0;
      endcase
   endfunction

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // inputs already driven at negedge; model the next edge, then compare
   task automatic step();
      bit hit;
      hit = m_busy && cond_f(m_kind, m_tgt, m_pat, m_msk, m_s2, sys_cnt);
      m_done = hit;
      if (!m_busy && req_valid && req_kind != 2'd3) begin
         m_busy = 1; m_kind = req_kind; m_tgt = req_target;
         m_pat = req_pattern; m_msk = req_mask;
      end else if (hit) m_busy = 0;
      m_s2 = m_s1; m_s1 = pins_in;
      @(negedge clk);
      check(busy == m_busy && done == m_done && core_ce == !m_busy, cur_tag,
            "busy/done/ce", {29'd0, busy, done, core_ce}, {29'd0, m_busy, m_done, !m_busy});
      sys_cnt = sys_cnt + 1;
      req_valid = 0;
   endtask

   task automatic request(logic [1:0] k, logic [31:0] t, logic [31:0] p, logic [31:0] m);
      req_valid = 1; req_kind = k; req_target = t; req_pattern = p; req_mask = m;
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(busy == 0 && done == 0 && core_ce == 1, "R1", "reset",
            {29'd0, busy, done, core_ce}, 32'b001);
      step();

      // R3 time wait, R7 pulse
      cur_tag = "R3 R7";
      request(2'd0, sys_cnt + 4, 0, 0);
      repeat (6) step();

      // R2 arm a pin-equal wait; R8 ignored request while busy
      cur_tag = "R2";
      pins_in = 32'h0;
      repeat (3) step();
      request(2'd1, 0, 32'h1, 32'h1);
      cur_tag = "R8";
      request(2'd0, sys_cnt + 1, 0, 0);
      request(2'd2, 0, 32'h1, 32'h1);
      repeat (3) step();
      // R6 synchronizer latency: done at exactly the third step
      cur_tag = "R6 R4";
      pins_in = 32'h1;
      repeat (5) step();

      // R11 reserved kind
      cur_tag = "R11";
      request(2'd3, sys_cnt + 1, 0, 0);
      repeat (3) step();
      check(busy == 0, "R11", "busy after reserved", {31'd0, busy}, 0);

      // R12 masked-off pins, then R5 differ
      cur_tag = "R12";
      pins_in = 32'h05;
      repeat (3) step();
      request(2'd2, 0, 32'h05, 32'h0F);
      for (int i = 0; i < 6; i++) begin
         pins_in = pins_in ^ 32'hFFFF_FF00;
         step();
      end
      check(busy == 1, "R12", "still waiting", {31'd0, busy}, 1);
      cur_tag = "R5";
      pins_in = pins_in ^ 32'h1;
      repeat (4) step();

      // R9 already-true condition
      cur_tag = "R9";
      pins_in = 32'hA0;
      repeat (3) step();
      request(2'd1, 0, 32'hA0, 32'hF0);
      check(busy == 1, "R9", "one stall cycle", {31'd0, busy}, 1);
      step();
      check(done == 1 && busy == 0, "R9", "done next edge", {30'd0, done, busy}, 32'b10);

      // R10 passed target needs wrap
      cur_tag = "R10";
      sys_cnt = 32'd10;
      request(2'd0, 32'd5, 0, 0);
      repeat (12) step();
      check(busy == 1, "R10", "no early match", {31'd0, busy}, 1);
      sys_cnt = 32'hFFFF_FFFC;
      repeat (12) step();
      check(busy == 0, "R10", "matched after wrap", {31'd0, busy}, 0);

      // random mix: R3 R4 R5 R7 R8
      cur_tag = "random R3 R4 R5 R7 R8";
      for (int c = 0; c < 3000; c++) begin
         if ($urandom % 3 == 0) pins_in = $urandom;
         if ($urandom % 4 == 0) begin
            logic [31:0] m;
            m = $urandom & $urandom & $urandom;
            req_valid = 1; req_kind = 2'($urandom % 4);
            req_target = sys_cnt + 1 + ($urandom % 16);
            req_mask = m; req_pattern = $urandom & m;
         end
         step();
      end
      finish_run();
   end
endmodule